// File: doc/BRIEF.md
# Dual-Processor Sync Register with Interrupt Controllers

This block lets two processors, side A and side B, exchange a four-bit status value and notify each other with an interrupt. Each side owns a 16-bit sync register. The four bits that a side writes into its upper nibble (bits 11:8) show up at once as the lower nibble (bits 3:0) of the other side's sync register. A side can also set a trigger bit in its write. The other side then receives an interrupt, but only when that side has enabled reception in its own sync register.

Each side also has a small interrupt controller. It holds a master enable, a 32-bit enable mask and a 32-bit request flag register. A sync interrupt sets flag bit 16. Software acknowledges a flag by writing a 1 to it. The interrupt output of a side is the combination of its master enable, the AND of mask and flags, and an interrupt-disable input that comes from that side's CPU.

Both sides use the same simple register port: a write strobe, an address, a size code, write data and combinational read data. Register offsets: sync 0x180, master enable 0x208, enable mask 0x210, request flags 0x214. The size code is 0 for 8 bits, 1 for 16 bits and 2 (or 3) for 32 bits. A write updates only the low-order byte lanes that the size covers.

Top module: `ipcs_top`

## Requirements
- R1: After reset every register of both sides reads 0, and both interrupt outputs are 0.
- R2: A 16- or 32-bit write of bits 11:8 to a side's sync register (offset 0x180) changes that side's readback bits 11:8 and the other side's readback bits 3:0 to the written value, from the clock edge that takes the write.
- R3: Bits 3:0 of a sync register cannot be written by the owning side; they always show the other side's bits 11:8.
- R4: Sync bit 14 is the receive-interrupt enable, read/write by its owner. Sync bit 13 and bits 15, 12 and 7:4 always read 0.
- R5: A sync write with bit 13 set sets bit 16 of the other side's request flags (offset 0x214) only if the other side's bit 14 is 1; otherwise no flag changes.
- R6: Writing the request flags clears each flag written as 1 within the written byte lanes; flags written as 0 are unchanged.
- R7: A side's irq output is 1 exactly when its master enable is 1, its cpu_irq_dis input is 0 and the mask AND flags is nonzero; the disable input acts in the same cycle.
- R8: The master enable (offset 0x208) takes bit 0 of 8-, 16- and 32-bit writes and reads back as bit 0 with all other bits 0.
- R9: If a flag-clear write and a new sync interrupt reach the same side in the same cycle, flag bit 16 remains set.
- R10: The enable mask (offset 0x210) is read/write, and a write changes only the byte lanes covered by its size (8 bits: 7:0, 16 bits: 15:0, 32 bits: all).
- R11: An 8-bit write to a sync register is ignored: no nibble, enable or interrupt changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_wr_en | input | 1 | Side A write strobe |
| a_addr | input | ADDR_W | Side A register offset |
| a_size | input | 2 | Side A access size: 0 byte, 1 half, 2/3 word |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data for a_addr |
| a_cpu_irq_dis | input | 1 | Side A CPU interrupt disable |
| a_irq | output | 1 | Side A interrupt request |
| b_wr_en | input | 1 | Side B write strobe |
| b_addr | input | ADDR_W | Side B register offset |
| b_size | input | 2 | Side B access size |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data for b_addr |
| b_cpu_irq_dis | input | 1 | Side B CPU interrupt disable |
| b_irq | output | 1 | Side B interrupt request |

## Verification
Every write is taken at one rising edge. Its effects, namely the owner's readback, the mirrored nibble on the far side, a remote request flag and any change of irq, are visible right after that edge, because read data and irq are formed combinationally from the registers. The bench therefore drives a write at the falling edge, removes it just after the following rising edge and samples a few nanoseconds later, before the next edge. The cpu_irq_dis input has no register in its path, so its effect on irq is checked within the same cycle it changes. After rst_n rises, the synchronised reset needs two more edges to release, and the bench waits longer than that before the first access.

// File: rtl/ipcs_pkg.sv
package ipcs_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned SYNC_W = 16;

  localparam logic [11:0] OFS_SYNC = 12'h180;
  localparam logic [11:0] OFS_MEN  = 12'h208;
  localparam logic [11:0] OFS_MASK = 12'h210;
  localparam logic [11:0] OFS_FLAG = 12'h214;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef struct packed {
    logic sync;
    logic men;
    logic mask;
    logic flag;
  } reg_sel_t;

  function automatic logic [REG_W-1:0] lane_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: lane_mask = 32'h0000_00FF;
      SZ_HALF: lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/ipcs_rst_sync.sv
module ipcs_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      stage_q <= 1'b0;
      rst_n_o <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_n_o <= stage_q;
    end
  end
endmodule

// File: rtl/ipcs_sync_pair.sv
module ipcs_sync_pair
  import ipcs_pkg::*;
#(
  parameter int unsigned NIB_W    = 4,
  parameter int unsigned OUT_LO   = 8,
  parameter int unsigned KICK_BIT = 13,
  parameter int unsigned RIE_BIT  = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            wr_sync,
  input  logic [SYNC_W-1:0]     wdata [2],
  output logic [SYNC_W-1:0]     sync_rd [2],
  output logic [1:0]            kick
);

  logic [NIB_W-1:0] out_q [2];
  logic [NIB_W-1:0] out_d [2];
  logic             rie_q [2];
  logic             rie_d [2];

  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam int unsigned R = 1 - s;

    always_comb begin
      out_d[s] = out_q[s];
      rie_d[s] = rie_q[s];
      if (wr_sync[s]) begin
        out_d[s] = wdata[s][OUT_LO +: NIB_W];
        rie_d[s] = wdata[s][RIE_BIT];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q[s] <= '0;
        rie_q[s] <= 1'b0;
      end else if (wr_sync[s]) begin
        out_q[s] <= out_d[s];
        rie_q[s] <= rie_d[s];
      end
    end

    assign kick[R] = wr_sync[s] & wdata[s][KICK_BIT] & rie_q[R];

    always_comb begin
      sync_rd[s]                   = '0;
      sync_rd[s][NIB_W-1:0]        = out_q[R];
      sync_rd[s][OUT_LO +: NIB_W]  = out_q[s];
      sync_rd[s][RIE_BIT]          = rie_q[s];
    end

    AST_MIRROR_FAR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sync[s] |=> sync_rd[R][NIB_W-1:0] == $past(wdata[s][OUT_LO +: NIB_W])); // R2
    AST_RIE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_sync[s] |=> $stable(sync_rd[s][RIE_BIT])); // R4
    AST_TRIGGER_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sync[s] |=> !sync_rd[s][KICK_BIT]); // R4
  end

endmodule

// File: rtl/ipcs_irq_ctrl.sv
module ipcs_irq_ctrl
  import ipcs_pkg::*;
#(
  parameter int unsigned SYNC_BIT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  reg_sel_t         sel,
  input  logic             wr_en,
  input  logic [1:0]       size,
  input  logic [REG_W-1:0] wdata,
  input  logic             set_sync,
  input  logic             cpu_irq_dis,
  output logic             men_q,
  output logic [REG_W-1:0] mask_q,
  output logic [REG_W-1:0] flag_q,
  output logic             irq_o
);

  logic             wr_men, wr_mask, wr_flag, upd_en;
  logic [REG_W-1:0] lanes;
  logic             men_d;
  logic [REG_W-1:0] mask_d, flag_d;

  assign wr_men  = wr_en & sel.men;
  assign wr_mask = wr_en & sel.mask;
  assign wr_flag = wr_en & sel.flag;
  assign lanes   = lane_mask(size);
  assign upd_en  = wr_men | wr_mask | wr_flag | set_sync;

  always_comb begin
    men_d  = men_q;
    mask_d = mask_q;
    flag_d = flag_q;
    if (wr_men)  men_d  = wdata[0];
    if (wr_mask) mask_d = (mask_q & ~lanes) | (wdata & lanes);
    if (wr_flag) flag_d = flag_q & ~(wdata & lanes);
    if (set_sync) flag_d[SYNC_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      men_q  <= 1'b0;
      mask_q <= '0;
      flag_q <= '0;
    end else if (upd_en) begin
      men_q  <= men_d;
      mask_q <= mask_d;
      flag_q <= flag_d;
    end
  end

  assign irq_o = men_q & ~cpu_irq_dis & (|(mask_q & flag_q));

  AST_MEN_FROM_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    wr_men |=> men_q == $past(wdata[0])); // R8
  AST_SYNC_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    set_sync |=> flag_q[SYNC_BIT]); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flag && wdata[SYNC_BIT] && lanes[SYNC_BIT] && !set_sync |=> !flag_q[SYNC_BIT]); // R6
  AST_FLAGS_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flag && !set_sync |=> $stable(flag_q)); // R5
  AST_FULL_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flag && ((flag_q & ~(wdata & lanes)) == '0) && !set_sync |=> !irq_o); // R7

endmodule

// File: rtl/ipcs_top.sv
module ipcs_top
  import ipcs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned SYNC_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_wr_en,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [1:0]        a_size,
  input  logic [31:0]       a_wdata,
  output logic [31:0]       a_rdata,
  input  logic              a_cpu_irq_dis,
  output logic              a_irq,
  input  logic              b_wr_en,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [1:0]        b_size,
  input  logic [31:0]       b_wdata,
  output logic [31:0]       b_rdata,
  input  logic              b_cpu_irq_dis,
  output logic              b_irq
);

  logic rst_n_s;

  ipcs_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  logic              wr_en_v  [2];
  logic [ADDR_W-1:0] addr_v   [2];
  logic [1:0]        size_v   [2];
  logic [REG_W-1:0]  wdata_v  [2];
  logic              dis_v    [2];
  logic [REG_W-1:0]  rdata_v  [2];
  logic              irq_v    [2];
  reg_sel_t          sel_v    [2];
  logic [1:0]        wr_sync;
  logic [SYNC_W-1:0] sync_wd  [2];
  logic [SYNC_W-1:0] sync_rd  [2];
  logic [1:0]        kick;
  logic              men_v    [2];
  logic [REG_W-1:0]  mask_v   [2];
  logic [REG_W-1:0]  flag_v   [2];

  assign wr_en_v[0] = a_wr_en;  assign wr_en_v[1] = b_wr_en;
  assign addr_v[0]  = a_addr;   assign addr_v[1]  = b_addr;
  assign size_v[0]  = a_size;   assign size_v[1]  = b_size;
  assign wdata_v[0] = a_wdata;  assign wdata_v[1] = b_wdata;
  assign dis_v[0]   = a_cpu_irq_dis;
  assign dis_v[1]   = b_cpu_irq_dis;
  assign a_rdata    = rdata_v[0];
  assign b_rdata    = rdata_v[1];
  assign a_irq      = irq_v[0];
  assign b_irq      = irq_v[1];

  for (genvar s = 0; s < 2; s++) begin : g_side
    assign sel_v[s].sync = addr_v[s] == ADDR_W'(OFS_SYNC);
    assign sel_v[s].men  = addr_v[s] == ADDR_W'(OFS_MEN);
    assign sel_v[s].mask = addr_v[s] == ADDR_W'(OFS_MASK);
    assign sel_v[s].flag = addr_v[s] == ADDR_W'(OFS_FLAG);

    assign wr_sync[s] = wr_en_v[s] & sel_v[s].sync & (size_v[s] != SZ_BYTE);
    assign sync_wd[s] = wdata_v[s][SYNC_W-1:0];

    ipcs_irq_ctrl #(.SYNC_BIT(SYNC_BIT)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n_s),
      .sel         (sel_v[s]),
      .wr_en       (wr_en_v[s]),
      .size        (size_v[s]),
      .wdata       (wdata_v[s]),
      .set_sync    (kick[s]),
      .cpu_irq_dis (dis_v[s]),
      .men_q       (men_v[s]),
      .mask_q      (mask_v[s]),
      .flag_q      (flag_v[s]),
      .irq_o       (irq_v[s])
    );

    always_comb begin
      unique case (1'b1)
        sel_v[s].sync: rdata_v[s] = {{(REG_W-SYNC_W){1'b0}}, sync_rd[s]};
        sel_v[s].men:  rdata_v[s] = {{(REG_W-1){1'b0}}, men_v[s]};
        sel_v[s].mask: rdata_v[s] = mask_v[s];
        sel_v[s].flag: rdata_v[s] = flag_v[s];
        default:       rdata_v[s] = '0;
      endcase
    end

    AST_BYTE_SYNC_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n_s)
      wr_en_v[s] && sel_v[s].sync && size_v[s] == SZ_BYTE && !wr_en_v[1-s]
      |=> $stable(flag_v[1-s])); // R11
  end

  ipcs_sync_pair u_pair (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_sync (wr_sync),
    .wdata   (sync_wd),
    .sync_rd (sync_rd),
    .kick    (kick)
  );

endmodule

// File: tb/tb_ipcs_top.sv
module tb_ipcs_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        a_wr_en, b_wr_en, a_dis, b_dis;
  logic [11:0] a_addr, b_addr;
  logic [1:0]  a_size, b_size;
  logic [31:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic        a_irq, b_irq;

  ipcs_top dut (
    .clk(clk), .rst_n(rst_n),
    .a_wr_en(a_wr_en), .a_addr(a_addr), .a_size(a_size), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_cpu_irq_dis(a_dis), .a_irq(a_irq),
    .b_wr_en(b_wr_en), .b_addr(b_addr), .b_size(b_size), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_cpu_irq_dis(b_dis), .b_irq(b_irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic        do_wr;
    logic        wside;
    logic [11:0] waddr;
    logic [1:0]  wsize;
    logic [31:0] wdata;
    logic        rside;
    logic [11:0] raddr;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 12'h180, 2'd1, 32'h0000_0500, 1'b1, 12'h180, 32'h0000_0005, 8'd2},  // R2
    '{1'b1, 1'b0, 12'h180, 2'd1, 32'h0000_0F0A, 1'b0, 12'h180, 32'h0000_0F00, 8'd3},  // R3
    '{1'b1, 1'b1, 12'h180, 2'd2, 32'h0000_4C00, 1'b0, 12'h180, 32'h0000_0F0C, 8'd2},  // R2
    '{1'b0, 1'b0, 12'h000, 2'd0, 32'h0000_0000, 1'b1, 12'h180, 32'h0000_4C0F, 8'd4},  // R4
    '{1'b1, 1'b0, 12'h180, 2'd1, 32'h0000_2F00, 1'b1, 12'h214, 32'h0001_0000, 8'd5},  // R5
    '{1'b0, 1'b0, 12'h000, 2'd0, 32'h0000_0000, 1'b0, 12'h180, 32'h0000_0F0C, 8'd4},  // R4
    '{1'b1, 1'b1, 12'h180, 2'd1, 32'h0000_2C00, 1'b0, 12'h214, 32'h0000_0000, 8'd5},  // R5
    '{1'b1, 1'b1, 12'h214, 2'd2, 32'h0000_0000, 1'b1, 12'h214, 32'h0001_0000, 8'd6},  // R6
    '{1'b1, 1'b1, 12'h214, 2'd2, 32'h0001_0000, 1'b1, 12'h214, 32'h0000_0000, 8'd6},  // R6
    '{1'b1, 1'b0, 12'h180, 2'd0, 32'h0000_6AFF, 1'b1, 12'h180, 32'h0000_0C0F, 8'd11}, // R11
    '{1'b1, 1'b0, 12'h210, 2'd2, 32'hFFFF_FFFF, 1'b0, 12'h210, 32'hFFFF_FFFF, 8'd10}, // R10
    '{1'b1, 1'b0, 12'h210, 2'd1, 32'h0000_0000, 1'b0, 12'h210, 32'hFFFF_0000, 8'd10}, // R10
    '{1'b1, 1'b0, 12'h210, 2'd0, 32'hFFFF_FF12, 1'b0, 12'h210, 32'hFFFF_0012, 8'd10}, // R10
    '{1'b1, 1'b0, 12'h208, 2'd0, 32'h0000_0001, 1'b0, 12'h208, 32'h0000_0001, 8'd8},  // R8
    '{1'b1, 1'b0, 12'h208, 2'd1, 32'h0000_FFFE, 1'b0, 12'h208, 32'h0000_0000, 8'd8},  // R8
    '{1'b1, 1'b0, 12'h208, 2'd2, 32'h0000_0003, 1'b0, 12'h208, 32'h0000_0001, 8'd8}   // R8
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic side, input logic [11:0] addr,
                           input logic [1:0] size, input logic [31:0] data);
    @(negedge clk);
    if (side == 1'b0) begin
      a_wr_en = 1'b1; a_addr = addr; a_size = size; a_wdata = data;
    end else begin
      b_wr_en = 1'b1; b_addr = addr; b_size = size; b_wdata = data;
    end
    @(posedge clk);
    #1;
    a_wr_en = 1'b0;
    b_wr_en = 1'b0;
  endtask

  task automatic read_reg(input logic side, input logic [11:0] addr, output logic [31:0] data);
    if (side == 1'b0) a_addr = addr; else b_addr = addr;
    #2;
    data = (side == 1'b0) ? a_rdata : b_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0;
    a_wr_en = 1'b0; b_wr_en = 1'b0; a_dis = 1'b0; b_dis = 1'b0;
    a_addr = '0; b_addr = '0; a_size = '0; b_size = '0; a_wdata = '0; b_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;

    // R1: reset state on both sides
    for (int s = 0; s < 2; s++) begin
      read_reg(s[0], 12'h180, rd); check("R1 sync", rd, 32'h0);
      read_reg(s[0], 12'h208, rd); check("R1 men", rd, 32'h0);
      read_reg(s[0], 12'h210, rd); check("R1 mask", rd, 32'h0);
      read_reg(s[0], 12'h214, rd); check("R1 flags", rd, 32'h0);
    end
    check("R1 a_irq", {31'h0, a_irq}, 32'h0);
    check("R1 b_irq", {31'h0, b_irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].do_wr)
        write_reg(VECS[i].wside, VECS[i].waddr, VECS[i].wsize, VECS[i].wdata);
      read_reg(VECS[i].rside, VECS[i].raddr, rd);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].exp);
    end

    // R7: A has men=1, mask=FFFF0012; enable reception on A, then B triggers
    write_reg(1'b0, 12'h180, 2'd1, 32'h0000_4F00);
    write_reg(1'b1, 12'h180, 2'd1, 32'h0000_2000);
    read_reg(1'b0, 12'h214, rd); check("R5 flag on A", rd, 32'h0001_0000);
    check("R7 irq on", {31'h0, a_irq}, 32'h1);
    a_dis = 1'b1; #2;
    check("R7 cpu disable", {31'h0, a_irq}, 32'h0);
    a_dis = 1'b0; #2;
    write_reg(1'b0, 12'h208, 2'd0, 32'h0000_0000);
    #2 check("R7 men off", {31'h0, a_irq}, 32'h0);
    write_reg(1'b0, 12'h208, 2'd0, 32'h0000_0001);
    write_reg(1'b0, 12'h210, 2'd2, 32'h0000_0012);
    #2 check("R7 masked", {31'h0, a_irq}, 32'h0);
    write_reg(1'b0, 12'h210, 2'd2, 32'hFFFF_FFFF);
    #2 check("R7 unmasked", {31'h0, a_irq}, 32'h1);

    // R6: byte-wide clear cannot reach bit 16
    write_reg(1'b0, 12'h214, 2'd0, 32'hFFFF_FFFF);
    read_reg(1'b0, 12'h214, rd); check("R6 byte lanes", rd, 32'h0001_0000);

    // R9: clear on A and trigger from B in the same cycle
    @(negedge clk);
    a_wr_en = 1'b1; a_addr = 12'h214; a_size = 2'd2; a_wdata = 32'h0001_0000;
    b_wr_en = 1'b1; b_addr = 12'h180; b_size = 2'd1; b_wdata = 32'h0000_2000;
    @(posedge clk);
    #1 a_wr_en = 1'b0; b_wr_en = 1'b0;
    read_reg(1'b0, 12'h214, rd); check("R9 set wins", rd, 32'h0001_0000);

    write_reg(1'b0, 12'h214, 2'd2, 32'h0001_0000);
    read_reg(1'b0, 12'h214, rd); check("R6 ack", rd, 32'h0);
    check("R7 irq after ack", {31'h0, a_irq}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule